// File: doc/BRIEF.md
# Calendar and binary time counter

This block is the time base of a real-time clock. It runs on the slow RTC clock and moves forward by one step in each cycle where a one-cycle tick enable from an external prescaler is high. A mode input decides how its single 43-bit state register is read and advanced. In binary mode the register is one free-running count. In calendar mode the same 43 bits hold eight separate fields: seconds, minutes, hours, day of month, month, year offset from 2000, weekday and week number. The day rollover follows the length of the current month and accounts for leap years.

The state is placed on one 43-bit output that an alarm comparator compares with its own value. Software sets the time through a synchronous load strobe and a 43-bit load word. A clear strobe returns the register to the zero point of the current mode. Only the active-low power-on reset resets the register asynchronously. No other reset in the system reaches it.

Calendar field positions inside the 43-bit word: seconds [5:0], minutes [11:6], hours [16:12], day [21:17], month [25:22], year [33:26], weekday [36:34], week [42:37].

Top module: `rtc_time_counter`

## Requirements
- R1: While por_n is low, time_q is forced at once to the calendar start value: week 1, weekday 1, year 0, month 1, day 1, and hour, minute and second all 0.
- R2: In a cycle where tick_en, load_strobe and clear_strobe are all low, time_q keeps its value in both modes.
- R3: In binary mode (cal_mode = 0), each tick adds 1 to the 43-bit value. All ones wraps to 0.
- R4: In calendar mode (cal_mode = 1), seconds count 0 to 59 and minutes count 0 to 59. A wrap from 59 to 0 carries one step into the next field up.
- R5: Hours count 0 to 23. A wrap from 23 to 0 advances the day.
- R6: The day wraps from the last day of the month to 1 and advances the month. April, June, September and November have 30 days. The other months have 31, except February.
- R7: February has 29 days when the year value is a multiple of 4 and is neither 100 nor 200. Otherwise it has 28 days.
- R8: The month wraps from 12 to 1 and advances the 8-bit year. The year wraps from 255 to 0.
- R9: The weekday advances by one on every day advance and wraps from 7 to 1.
- R10: The week advances when the weekday wraps from 7 to 1, and holds at 52. At a year rollover the week becomes 1, and this overrides the normal advance.
- R11: When load_strobe is high and clear_strobe is low, time_q takes load_value on the next edge, even if tick_en is high in the same cycle.
- R12: When clear_strobe is high, time_q becomes 0 in binary mode or the R1 calendar start value in calendar mode on the next edge. Clear overrides both load and tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Slow RTC clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| cal_mode | input | 1 | 1 = calendar mode, 0 = binary mode |
| tick_en | input | 1 | One-cycle advance pulse from the prescaler |
| clear_strobe | input | 1 | Synchronous return to the current mode's zero point |
| load_strobe | input | 1 | Synchronous write of load_value into the register |
| load_value | input | 43 | Value to load, using the field layout above |
| time_q | output | 43 | Counter state sent to the alarm comparator |

## Verification
The hardest cases to reach are the long carry chains: the end-of-month day rollover under each leap-year rule, and the year-end step that resets the week field. From reset these cases lie millions of ticks away. The bench therefore uses the load strobe to place the counter one tick before each boundary, gives a single tick, and compares the whole 43-bit word with a value built field by field. A short run of ordinary ticks from reset checks that the seconds and minutes carry also works without a preload.

// File: rtl/rtc_time_counter.sv
module rtc_time_counter (
  input  logic        clk_rtc,
  input  logic        por_n,
  input  logic        cal_mode,
  input  logic        tick_en,
  input  logic        clear_strobe,
  input  logic        load_strobe,
  input  logic [42:0] load_value,
  output logic [42:0] time_q
);
  localparam logic [42:0] CAL_START = {6'd1, 3'd1, 8'd0, 4'd1, 5'd1, 5'd0, 6'd0, 6'd0};

  wire [5:0] sec   = time_q[5:0];
  wire [5:0] mins  = time_q[11:6];
  wire [4:0] hour  = time_q[16:12];
  wire [4:0] day   = time_q[21:17];
  wire [3:0] month = time_q[25:22];
  wire [7:0] year  = time_q[33:26];
  wire [2:0] wday  = time_q[36:34];
  wire [5:0] week  = time_q[42:37];

  wire leap = (year[1:0] == 2'd0) && (year != 8'd100) && (year != 8'd200);

  logic [4:0] month_len;
  always_comb begin
    case (month)
      4'd2:                       month_len = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    month_len = 5'd30;
      default:                    month_len = 5'd31;
    endcase
  end

  wire sec_top  = sec >= 6'd59;
  wire min_top  = mins >= 6'd59;
  wire hour_top = hour >= 5'd23;
  wire day_top  = day >= month_len;
  wire mon_top  = month >= 4'd12;
  wire wday_top = wday >= 3'd7;
  wire week_top = week >= 6'd52;

  wire go_min  = sec_top;
  wire go_hour = go_min & min_top;
  wire go_day  = go_hour & hour_top;
  wire go_mon  = go_day & day_top;
  wire go_year = go_mon & mon_top;

  wire [5:0] n_sec   = sec_top ? 6'd0 : sec + 6'd1;
  wire [5:0] n_min   = go_min  ? (min_top  ? 6'd0 : mins + 6'd1) : mins;
  wire [4:0] n_hour  = go_hour ? (hour_top ? 5'd0 : hour + 5'd1) : hour;
  wire [4:0] n_day   = go_day  ? (day_top  ? 5'd1 : day + 5'd1)  : day;
  wire [3:0] n_month = go_mon  ? (mon_top  ? 4'd1 : month + 4'd1) : month;
  wire [7:0] n_year  = go_year ? year + 8'd1 : year;
  wire [2:0] n_wday  = go_day  ? (wday_top ? 3'd1 : wday + 3'd1) : wday;
  wire [5:0] n_week  = go_year ? 6'd1 :
                       (go_day && wday_top && !week_top) ? week + 6'd1 : week;

  wire [42:0] cal_next = {n_week, n_wday, n_year, n_month, n_day, n_hour, n_min, n_sec};

  always_ff @(posedge clk_rtc or negedge por_n) begin
    if (!por_n)            time_q <= CAL_START;
    else if (clear_strobe) time_q <= cal_mode ? CAL_START : 43'd0;
    else if (load_strobe)  time_q <= load_value;
    else if (tick_en)      time_q <= cal_mode ? cal_next : time_q + 43'd1;
  end

  assert_hold_R2: assert property (@(posedge clk_rtc) disable iff (!por_n)
    (!tick_en && !load_strobe && !clear_strobe) |=> $stable(time_q));

  assert_bin_step_R3: assert property (@(posedge clk_rtc) disable iff (!por_n)
    (!cal_mode && tick_en && !load_strobe && !clear_strobe) |=> (time_q == $past(time_q) + 43'd1));

  assert_sec_range_R4: assert property (@(posedge clk_rtc) disable iff (!por_n)
    (cal_mode && tick_en && !load_strobe && !clear_strobe && sec < 6'd59) |=> (time_q[5:0] == $past(sec) + 6'd1));

  assert_hour_range_R5: assert property (@(posedge clk_rtc) disable iff (!por_n)
    (cal_mode && tick_en && !load_strobe && !clear_strobe && hour <= 5'd23) |=> (time_q[16:12] <= 5'd23));

  assert_load_R11: assert property (@(posedge clk_rtc) disable iff (!por_n)
    (load_strobe && !clear_strobe) |=> (time_q == $past(load_value)));

  assert_clear_R12: assert property (@(posedge clk_rtc) disable iff (!por_n)
    (clear_strobe && !cal_mode) |=> (time_q == 43'd0));
endmodule

// File: tb/rtc_time_counter_tb_top.sv
module rtc_time_counter_tb_top;
  logic        clk_rtc = 1'b0;
  logic        por_n = 1'b0;
  logic        cal_mode = 1'b1;
  logic        tick_en = 1'b0;
  logic        clear_strobe = 1'b0;
  logic        load_strobe = 1'b0;
  logic [42:0] load_value = '0;
  logic [42:0] time_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_rtc = ~clk_rtc;

  rtc_time_counter dut_i (
    .clk_rtc(clk_rtc), .por_n(por_n), .cal_mode(cal_mode), .tick_en(tick_en),
    .clear_strobe(clear_strobe), .load_strobe(load_strobe),
    .load_value(load_value), .time_q(time_q)
  );

  function automatic logic [42:0] cal(input int wk, input int wd, input int yr, input int mo,
                                      input int dy, input int hr, input int mi, input int se);
    cal = {wk[5:0], wd[2:0], yr[7:0], mo[3:0], dy[4:0], hr[4:0], mi[5:0], se[5:0]};
  endfunction

  localparam logic [42:0] START = {6'd1, 3'd1, 8'd0, 4'd1, 5'd1, 5'd0, 6'd0, 6'd0};

  // {mode, preload, expected after one tick, requirement number}
  localparam int NV = 17;
  localparam logic [90:0] VEC [NV] = '{
    {1'b1, cal(1,1,0,1,1,0,0,10),      cal(1,1,0,1,1,0,0,11),    4'd4},  // R4
    {1'b1, cal(1,1,0,1,1,0,5,59),      cal(1,1,0,1,1,0,6,0),     4'd4},  // R4
    {1'b1, cal(1,1,0,1,1,5,59,59),     cal(1,1,0,1,1,6,0,0),     4'd5},  // R5
    {1'b1, cal(2,3,0,1,10,23,59,59),   cal(2,4,0,1,11,0,0,0),    4'd5},  // R5 R9
    {1'b1, cal(17,2,5,4,30,23,59,59),  cal(17,3,5,5,1,0,0,0),    4'd6},  // R6
    {1'b1, cal(5,1,5,1,30,23,59,59),   cal(5,2,5,1,31,0,0,0),    4'd6},  // R6
    {1'b1, cal(48,4,7,11,30,23,59,59), cal(48,5,7,12,1,0,0,0),   4'd6},  // R6
    {1'b1, cal(9,5,4,2,28,23,59,59),   cal(9,6,4,2,29,0,0,0),    4'd7},  // R7
    {1'b1, cal(9,6,5,2,28,23,59,59),   cal(9,7,5,3,1,0,0,0),     4'd7},  // R7
    {1'b1, cal(9,7,100,2,28,23,59,59), cal(10,1,100,3,1,0,0,0),  4'd7},  // R7 R10
    {1'b1, cal(9,3,0,2,28,23,59,59),   cal(9,4,0,2,29,0,0,0),    4'd7},  // R7
    {1'b1, cal(52,7,20,12,31,23,59,59),cal(1,1,21,1,1,0,0,0),    4'd8},  // R8 R10
    {1'b1, cal(52,2,255,12,31,23,59,59),cal(1,3,0,1,1,0,0,0),    4'd8},  // R8
    {1'b1, cal(52,7,9,12,27,23,59,59), cal(52,1,9,12,28,0,0,0),  4'd10}, // R10
    {1'b0, {43{1'b1}},                 43'd0,                    4'd3},  // R3
    {1'b0, 43'h123,                    43'h124,                  4'd3},  // R3
    {1'b0, 43'h0_FFFF_FFFF,            43'h1_0000_0000,          4'd3}   // R3
  };

  task automatic check(input string req, input logic [42:0] act, input logic [42:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic tk, input logic ld, input logic clr, input logic [42:0] v);
    @(negedge clk_rtc);
    tick_en = tk; load_strobe = ld; clear_strobe = clr; load_value = v;
    @(posedge clk_rtc);
    #1;
    tick_en = 1'b0; load_strobe = 1'b0; clear_strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_rtc);
    check("R1 reset value", time_q, START);
    por_n = 1'b1;
    repeat (4) cycle(1'b0, 1'b0, 1'b0, '0);
    check("R2 hold calendar", time_q, START);

    for (int i = 0; i < NV; i++) begin
      cal_mode = VEC[i][90];
      cycle(1'b0, 1'b1, 1'b0, VEC[i][89:47]);
      cycle(1'b1, 1'b0, 1'b0, '0);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), time_q, VEC[i][46:4]);
    end

    cal_mode = 1'b0;
    cycle(1'b0, 1'b1, 1'b0, 43'd100);
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, 1'b0, '0);
    check("R3 ten ticks", time_q, 43'd110);
    repeat (3) cycle(1'b0, 1'b0, 1'b0, '0);
    check("R2 hold binary", time_q, 43'd110);

    cycle(1'b1, 1'b1, 1'b0, 43'h55);
    check("R11 load beats tick", time_q, 43'h55);
    cycle(1'b1, 1'b1, 1'b1, 43'h77);
    check("R12 clear binary", time_q, 43'd0);
    cal_mode = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, cal(3,3,3,3,3,3,3,3));
    check("R11 load calendar", time_q, cal(3,3,3,3,3,3,3,3));
    cycle(1'b1, 1'b1, 1'b1, cal(4,4,4,4,4,4,4,4));
    check("R12 clear calendar", time_q, START);

    for (int i = 0; i < 70; i++) cycle(1'b1, 1'b0, 1'b0, '0);
    check("R4 seventy ticks", time_q, cal(1,1,0,1,1,0,1,10));

    @(negedge clk_rtc);
    por_n = 1'b0;
    #1;
    check("R1 async reset", time_q, START);
    @(negedge clk_rtc);
    por_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule